// File: doc/BRIEF.md
# Addressed Transmit Pipe Endpoint

This block is one transmit endpoint on a shared host-link bus. A central interface broadcasts a request word to every endpoint. The word holds a target address, an active flag, a downstream-full flag and the number of bytes the host still wants. When the active flag is set and the target address equals this endpoint's own address, the endpoint asks its user logic for bytes. It does this by raising a write-request output for one cycle per byte it wants.

The user logic answers with a fixed one-cycle latency. A byte requested in cycle t is presented on the data input during cycle t+1. The endpoint captures it and drives it onto a return word together with a valid bit. Every endpoint's return word is merged with the others by a bitwise OR, so the word is all zeros unless this endpoint has something to report.

The user can stall the stream with a pause input. Because of the one-cycle latency, one byte already granted still arrives after pause is raised. Pause may also be held before any request arrives. While this endpoint is addressed and paused, a hold bit in the return word tells the central interface why the stream has stopped.

Top module: `txpipe_endpoint`

## Requirements
- R1: The request word layout is: [6:0] target address, [7] active, [8] downstream full, [18:9] remaining byte count. `wr_req_o` is high in a cycle only if, at the preceding clock edge, the active bit was set and the target address equalled `my_addr_i`.
- R2: A downstream-full flag sampled high at a clock edge makes `wr_req_o` low for the following cycle.
- R3: A pause sampled high at a clock edge makes `wr_req_o` low for the following cycle. The byte for a request made in the cycle in which pause rose is still captured, so exactly one byte follows the pause edge.
- R4: `wr_req_o` goes high one edge after the conditions allow it: addressed, not full, not paused, and credit left. This covers the first cycle of a request and the cycle after pause or full is released.
- R5: The remaining count is loaded on the first addressed cycle. Each cycle with `wr_req_o` high uses one unit of it. The number of `wr_req_o` cycles in one request equals the loaded count, and `wr_req_o` stays low once it is used up.
- R6: The byte on `data_i` during the cycle after a `wr_req_o` cycle is captured and shown on `ret_o` with the valid bit set two cycles after that `wr_req_o` cycle. Bytes arrive in order, with no gaps or repeats. `data_i` in any other cycle has no effect on `ret_o`.
- R7: The return word layout is: [7:0] byte, [8] valid, [9] hold. The byte field is zero whenever valid is low.
- R8: The hold bit is high in the cycle after an edge at which the endpoint was addressed and pause was high, and low otherwise.
- R9: While reset is asserted, `wr_req_o` is low and `ret_o` is all zeros.
- R10: If the active bit drops in the middle of a request, the unused count is discarded. A later request reloads the count from the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| my_addr_i | input | 7 | Address this endpoint answers to |
| bcast_i | input | 19 | Request word broadcast by the central interface |
| pause_i | input | 1 | User stall request |
| wr_req_o | output | 1 | Asks the user for one byte, due in the next cycle |
| data_i | input | 8 | User byte, valid in the cycle after a request |
| ret_o | output | 10 | OR-mergeable return word: byte, valid, hold |

## Verification
The case that matters most is a pause edge, a full flag or the last unit of credit landing in the same cycle as a request, or right after one. Any of these must stop the next request, and the byte already granted must still be taken. The bench provokes such collisions with short random counts and independent random pause and full toggles on every cycle. It also runs directed cases: a one-byte request, pause held before the request, full held from the start, and a request cut short then reissued. Each cycle it compares `wr_req_o`, valid and hold against a cycle model of the rules. It then compares the captured stream against the byte sequence the modelled user supplied, so a skipped or doubled byte shows up as a miscompare.

// File: rtl/txp_pkg.sv
package txp_pkg;

  localparam int unsigned DEF_ADDR_W = 7;
  localparam int unsigned DEF_DATA_W = 8;
  localparam int unsigned DEF_CNT_W  = 10;

  // Credit left after this cycle: cleared when not addressed, loaded on a new
  // request, reduced by one for every request already issued.
  function automatic int unsigned credit_next(input logic sel, input logic start,
                                              input logic used, input int unsigned load,
                                              input int unsigned cur);
    if (!sel)  return 0;
    if (start) return load;
    if (used && cur != 0) return cur - 1;
    return cur;
  endfunction

endpackage

// File: rtl/txp_grant.sv
module txp_grant #(
  parameter int ADDR_W = 7,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bc_addr_i,
  input  logic              bc_active_i,
  input  logic              bc_full_i,
  input  logic [CNT_W-1:0]  bc_rem_i,
  input  logic [ADDR_W-1:0] my_addr_i,
  input  logic              pause_i,
  output logic              sel_o,
  output logic              wr_req_o
);

  logic             sel_q;
  logic             start_w;
  logic             req_d;
  logic [CNT_W-1:0] left_q;
  logic [CNT_W-1:0] left_d;

  assign sel_o   = bc_active_i && (bc_addr_i == my_addr_i);
  assign start_w = sel_o && !sel_q;

  always_comb begin
    left_d = CNT_W'(txp_pkg::credit_next(sel_o, start_w, wr_req_o,
                                         32'(bc_rem_i), 32'(left_q)));
    req_d  = sel_o && !bc_full_i && !pause_i && (left_d != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= 1'b0;
      left_q   <= '0;
      wr_req_o <= 1'b0;
    end else begin
      sel_q    <= sel_o;
      left_q   <= left_d;
      wr_req_o <= req_d;
    end
  end

  // R1: no request toward the user unless addressed at the prior edge
  a_r1_unaddressed: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_o |=> !wr_req_o);

  // R2: downstream full stops the next request
  a_r2_full_stops: assert property (@(posedge clk) disable iff (!rst_n)
    bc_full_i |=> !wr_req_o);

  // R3: pause stops the next request
  a_r3_pause_stops: assert property (@(posedge clk) disable iff (!rst_n)
    pause_i |=> !wr_req_o);

  // R5: the request that uses the last credit is followed by silence
  a_r5_last_credit: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_o && left_q == CNT_W'(1)) |=> !wr_req_o);

  // R10: a fresh request reloads the credit from the bus
  a_r10_reload: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> (left_q == $past(bc_rem_i)));

endmodule

// File: rtl/txp_capture.sv
module txp_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              sel_i,
  input  logic              pause_i,
  output logic [DATA_W-1:0] byte_o,
  output logic              valid_o,
  output logic              hold_o
);

  logic take_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q  <= 1'b0;
      byte_o  <= '0;
      valid_o <= 1'b0;
      hold_o  <= 1'b0;
    end else begin
      take_q  <= grant_i;
      valid_o <= take_q;
      hold_o  <= sel_i && pause_i;
      if (take_q) byte_o <= data_i;
    end
  end

endmodule

// File: rtl/txp_retbus.sv
module txp_retbus #(
  parameter int DATA_W = 8
) (
  input  logic              valid_i,
  input  logic              hold_i,
  input  logic [DATA_W-1:0] byte_i,
  output logic [DATA_W+1:0] ret_o
);

  localparam int VALID_BIT = DATA_W;
  localparam int HOLD_BIT  = DATA_W + 1;

  always_comb begin
    ret_o              = '0;
    ret_o[VALID_BIT]   = valid_i;
    ret_o[HOLD_BIT]    = hold_i;
    if (valid_i) ret_o[DATA_W-1:0] = byte_i;
  end

endmodule

// File: rtl/txpipe_endpoint.sv
module txpipe_endpoint #(
  parameter int ADDR_W = txp_pkg::DEF_ADDR_W,
  parameter int DATA_W = txp_pkg::DEF_DATA_W,
  parameter int CNT_W  = txp_pkg::DEF_CNT_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          my_addr_i,
  input  logic [ADDR_W+CNT_W+1:0]    bcast_i,
  input  logic                       pause_i,
  output logic                       wr_req_o,
  input  logic [DATA_W-1:0]          data_i,
  output logic [DATA_W+1:0]          ret_o
);

  localparam int ACT_BIT  = ADDR_W;
  localparam int FULL_BIT = ADDR_W + 1;
  localparam int REM_LSB  = ADDR_W + 2;

  logic [ADDR_W-1:0] bc_addr_w;
  logic              bc_active_w;
  logic              bc_full_w;
  logic [CNT_W-1:0]  bc_rem_w;
  logic              sel_w;
  logic [DATA_W-1:0] cap_byte_w;
  logic              cap_valid_w;
  logic              cap_hold_w;

  assign bc_addr_w   = bcast_i[ADDR_W-1:0];
  assign bc_active_w = bcast_i[ACT_BIT];
  assign bc_full_w   = bcast_i[FULL_BIT];
  assign bc_rem_w    = bcast_i[REM_LSB +: CNT_W];

  txp_grant #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) grant_i (
    .clk(clk), .rst_n(rst_n),
    .bc_addr_i(bc_addr_w), .bc_active_i(bc_active_w),
    .bc_full_i(bc_full_w), .bc_rem_i(bc_rem_w),
    .my_addr_i(my_addr_i), .pause_i(pause_i),
    .sel_o(sel_w), .wr_req_o(wr_req_o)
  );

  txp_capture #(.DATA_W(DATA_W)) capture_i (
    .clk(clk), .rst_n(rst_n),
    .grant_i(wr_req_o), .data_i(data_i),
    .sel_i(sel_w), .pause_i(pause_i),
    .byte_o(cap_byte_w), .valid_o(cap_valid_w), .hold_o(cap_hold_w)
  );

  txp_retbus #(.DATA_W(DATA_W)) retbus_i (
    .valid_i(cap_valid_w), .hold_i(cap_hold_w),
    .byte_i(cap_byte_w), .ret_o(ret_o)
  );

  // R6: every request yields a valid byte two cycles later
  a_r6_byte_follows: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o |-> ##2 ret_o[DATA_W]);

  // R7: without a request two cycles back, byte and valid fields stay quiet
  a_r7_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_req_o, 2) |-> (ret_o[DATA_W:0] == '0));

  // R8: hold follows an addressed, paused cycle
  a_r8_hold_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_w && pause_i) |=> ret_o[DATA_W+1]);

endmodule

// File: tb/txpipe_endpoint_tb.sv
`timescale 1ns/100ps
module txpipe_endpoint_tb_top;

  localparam logic [6:0] MY = 7'h2B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [18:0] bcast = '0;
  logic        pause = 1'b0;
  logic        wr_req;
  logic [7:0]  data = '0;
  logic [9:0]  ret;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  // bench-side model state
  logic [6:0] cur_addr = '0;
  logic cur_act = 0, cur_full = 0, cur_pz = 0;
  int   cur_rem = 0;
  logic old_sel = 0, prev_wr = 0, hist1 = 0, hist2 = 0, wr_seen = 0;
  int   e_left = 0, cap_idx = 0, u_idx = 0, xfer_grants = 0, all_grants = 0;

  always #2.5 clk = ~clk;

  txpipe_endpoint dut_i (
    .clk(clk), .rst_n(rst_n), .my_addr_i(MY), .bcast_i(bcast),
    .pause_i(pause), .wr_req_o(wr_req), .data_i(data), .ret_o(ret)
  );

  function automatic logic [7:0] byte_of(int k);
    return 8'((k * 73 + 11) ^ (k >>> 3));
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // user side: answers a request seen in cycle t with a byte during t+1
  initial forever begin
    @(posedge clk); #1;
    if (wr_seen) begin
      data = byte_of(u_idx);
      u_idx++;
    end else begin
      data = 8'($urandom);
    end
  end

  task automatic evaluate();
    logic sel_c, start, exp_wr, exp_h;
    string tag;
    sel_c = cur_act && (cur_addr == MY);
    start = sel_c && !old_sel;
    if (!sel_c) e_left = 0;
    else if (start) e_left = cur_rem;
    else if (prev_wr && e_left != 0) e_left = e_left - 1;
    exp_wr = sel_c && !cur_full && !cur_pz && (e_left != 0);
    if (!sel_c) tag = "R1";
    else if (cur_full) tag = "R2";
    else if (cur_pz) tag = "R3";
    else if (e_left == 0) tag = "R5";
    else if (start) tag = "R10";
    else tag = "R4";
    check(wr_req === exp_wr, tag, int'(wr_req), int'(exp_wr));
    check(ret[8] === hist2, "R6", int'(ret[8]), int'(hist2));
    if (ret[8] && hist2) begin
      check(ret[7:0] === byte_of(cap_idx), "R6", int'(ret[7:0]), int'(byte_of(cap_idx)));
      cap_idx++;
    end else if (!ret[8]) begin
      check(ret[7:0] === 8'h00, "R7", int'(ret[7:0]), 0);
    end
    exp_h = sel_c && cur_pz;
    check(ret[9] === exp_h, "R8", int'(ret[9]), int'(exp_h));
    old_sel = sel_c;
    prev_wr = wr_req;
    hist2 = hist1;
    hist1 = wr_req;
    wr_seen = wr_req;
    if (wr_req) begin xfer_grants++; all_grants++; end
  endtask

  task automatic step(logic [6:0] a, logic act, logic fl, int rem, logic pz);
    @(negedge clk);
    evaluate();
    cur_addr = a; cur_act = act; cur_full = fl; cur_rem = rem; cur_pz = pz;
    bcast = {10'(rem), fl, act, a};
    pause = pz;
  endtask

  task automatic run_to_end(int rem, int p_pause, int p_full);
    int cyc = 0;
    while (xfer_grants < rem && cyc < 2000) begin
      step(MY, 1'b1, ($urandom % 100) < p_full, rem, ($urandom % 100) < p_pause);
      cyc++;
    end
    repeat (3) step(MY, 1'b0, 1'b0, 0, 1'b0);
    check(xfer_grants == rem, "R5", xfer_grants, rem);
  endtask

  initial begin
    void'($urandom(32'd7719));
    repeat (3) @(negedge clk);
    check(wr_req === 1'b0, "R9", int'(wr_req), 0);
    check(ret === 10'h000, "R9", int'(ret), 0);
    rst_n = 1'b1;

    // R1: another endpoint's address draws no request
    repeat (6) step(MY ^ 7'h01, 1'b1, 1'b0, 20, 1'b0);
    repeat (2) step(MY, 1'b0, 1'b0, 0, 1'b0);
    check(all_grants == 0, "R1", all_grants, 0);

    // R3/R4: pause held before the request arrives, then released
    xfer_grants = 0;
    repeat (2) step(MY, 1'b0, 1'b0, 0, 1'b1);
    repeat (3) step(MY, 1'b1, 1'b0, 6, 1'b1);
    run_to_end(6, 0, 0);

    // R5: single byte request
    xfer_grants = 0;
    run_to_end(1, 0, 0);

    // R2: full held from the start
    xfer_grants = 0;
    repeat (3) step(MY, 1'b1, 1'b1, 4, 1'b0);
    run_to_end(4, 0, 0);

    // R3: pause raised mid-stream, one more byte must still land
    xfer_grants = 0;
    repeat (3) step(MY, 1'b1, 1'b0, 8, 1'b0);
    repeat (2) step(MY, 1'b1, 1'b0, 8, 1'b1);
    run_to_end(8, 0, 0);

    // R10: request cut short, then reissued with a new count
    repeat (4) step(MY, 1'b1, 1'b0, 10, 1'b0);
    repeat (2) step(MY, 1'b0, 1'b0, 0, 1'b0);
    xfer_grants = 0;
    run_to_end(5, 0, 0);
    check(xfer_grants == 5, "R10", xfer_grants, 5);

    // constrained random requests with colliding pause and full
    for (int i = 0; i < 250; i++) begin
      if ((i % 7) == 3) repeat (2) step(MY ^ 7'h10, 1'b1, 1'b0, 9, 1'b0);
      xfer_grants = 0;
      run_to_end(1 + int'($urandom % 40), 25, 15);
    end

    repeat (3) step(MY, 1'b0, 1'b0, 0, 1'b0);
    check(cap_idx == u_idx, "R6", cap_idx, u_idx);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule